// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a synchronous serial slave that gives a host read and write access to a bank of 32 byte-wide configuration registers. Every access opens with an 8-bit instruction that selects the direction, a count of one to four data bytes and a 5-bit start address. The data bytes follow in the same select window, and the address steps automatically from one byte to the next. The serial pins are oversampled in the system clock domain, so the whole bank is synchronous to `clk` and the register contents leave the block as one flat vector.

Register 0 holds the port's own settings:

| Bit | Meaning |
|---|---|
| 7 | Returns read data on the shared data pin instead of the separate output |
| 6 | Selects least-significant-bit-first ordering |
| 5 | Triggers a soft reset of the rest of the bank |

These settings act on the port as soon as the byte that carries them has been received, even in the middle of an access. One address is a read-only identification constant.

Top module: `spi_cfg_port`

## Requirements
- R1: The instruction byte is decoded as follows. Bit 7 = 1 requests a read and 0 a write. Bits 6:5 = 00/01/10/11 request 1/2/3/4 data bytes. Bits 4:0 give the start address.
- R2: The port samples serial input on the rising edge of `sclk`. A written byte appears in its register, visible on `cfg_bank[8*a+7:8*a]`, once the last bit of that byte has been received. After reset the ordering is most-significant-bit first.
- R3: With MSB-first ordering, each further byte goes to the address one below the previous one, wrapping from 00h to 1Fh. With LSB-first ordering, each further byte goes one above, wrapping from 1Fh to 00h.
- R4: Setting register 0 bit 6 makes both instruction and data bytes travel LSB first. A change written mid-access governs the bit order of the next byte. The step that follows the byte carrying the change still uses the previous ordering.
- R5: Read data is driven on the falling edge of `sclk` and is valid at the following rising edge. Each byte is fetched at the byte boundary, and multi-byte reads follow the stepped addresses.
- R6: When `sel_n` goes high, the port aborts and returns to the instruction phase. A partly received byte is never written.
- R7: Once the requested number of data bytes has passed, further `sclk` edges in the same select window change nothing.
- R8: With register 0 bit 7 clear, read data leaves on `sdo_out` with `sdo_oe` high and `sdio_oe` low. With the bit set, read data leaves on `sdio_out`, `sdio_oe` is high only during the read data phase, and `sdo_oe` is low. While `sel_n` is high, both enables are low. The two enables are never high together.
- R9: Writing register 0 with bit 5 set returns registers 1..31 to their defaults. Register 1 defaults to 02h and all others to 00h. Register 0 keeps bits 7 and 6 from the written value, and bit 5 always reads 0.
- R10: The synchronous `rst` input returns every register, register 0 included, to its default.
- R11: Address 1Fh always reads 5Ah, and writes to it are ignored.
- R12: Out of reset, both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst | input | 1 | Synchronous active-high hardware reset |
| sel_n | input | 1 | Active-low select; high aborts the access |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Serial data input (shared data pin, input side) |
| sdio_out | output | 1 | Read data for the shared data pin |
| sdio_oe | output | 1 | Drive enable for the shared data pin |
| sdo_out | output | 1 | Read data for the separate output pin |
| sdo_oe | output | 1 | Drive enable for the separate output pin |
| cfg_bank | output | 256 | All 32 registers, register a in bits 8a+7..8a |

## Verification
Accesses of one to four bytes are issued in both bit orders, so ordering faults and stepping faults show up as different wrong registers. A start near 00h in MSB-first mode and near 1Fh in LSB-first mode isolates the wrap, and the read-only address sits in those windows. An access that rewrites register 0 mid-stream separates an ordering change that is applied too early from one applied too late. Aborted bytes, surplus bytes and soft versus hardware reset each leave a bank image that only the intended behaviour produces. Reads are taken on both data pins, with the enables watched at every sampled bit.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    localparam int ADDR_W   = 5;
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = $clog2(BYTE_W);
    localparam int BANK_W   = NUM_REGS * BYTE_W;

    // register 0 control bits
    localparam int CFG_BIDIR_BIT = 7;
    localparam int CFG_LSB_BIT   = 6;
    localparam int CFG_SRST_BIT  = 5;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t SRST_MASK = byte_t'(1 << CFG_SRST_BIT);

    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_DATA  = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;

    // instruction layout: direction, byte count minus one, start address
    typedef struct packed {
        logic       rd;
        logic [1:0] len;
        addr_t      addr;
    } instr_t;

    function automatic instr_t decode_instr(byte_t b);
        return instr_t'(b);
    endfunction

    function automatic byte_t shift_in(byte_t sh, logic b, logic lsb_first);
        return lsb_first ? {b, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], b};
    endfunction

    function automatic addr_t step_addr(addr_t a, logic lsb_first);
        return lsb_first ? addr_t'(a + 1'b1) : addr_t'(a - 1'b1);
    endfunction

    function automatic byte_t reg_default(int idx);
        return (idx == 1) ? 8'h02 : 8'h00;
    endfunction
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic sel_n_i,
    input  logic sdi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sel_act,
    output logic sdi
);
    logic [STAGES-1:0] sclk_q;
    logic [STAGES-1:0] sel_q;
    logic [STAGES-1:0] sdi_q;
    logic              sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= '0;
            sel_q  <= '1;
            sdi_q  <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
            sel_q  <= {sel_q[STAGES-2:0], sel_n_i};
            sdi_q  <= {sdi_q[STAGES-2:0], sdi_i};
            sclk_d <= sclk_q[STAGES-1];
        end
    end

    assign sclk_rise = sclk_q[STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_q[STAGES-1] & sclk_d;
    assign sel_act   = ~sel_q[STAGES-1];
    assign sdi       = sdi_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_engine.sv
module spi_cfg_engine
    import spi_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rise,
    input  logic  fall,
    input  logic  sel_act,
    input  logic  sdi,
    input  logic  lsb_first,
    input  byte_t rd_data,
    output logic  wr_en,
    output addr_t wr_addr,
    output byte_t wr_data,
    output addr_t rd_addr,
    output logic  out_bit,
    output logic  rd_phase
);
    phase_e           phase;
    logic [CNT_W-1:0] bit_cnt;
    byte_t            rx_sh;
    byte_t            tx_sh;
    byte_t            rx_next;
    logic             rd_q;
    logic [1:0]       left;
    addr_t            cur_addr;
    instr_t           ins;
    logic             byte_done;

    always_comb begin
        rx_next   = shift_in(rx_sh, sdi, lsb_first);
        ins       = decode_instr(rx_next);
        byte_done = sel_act && rise && (phase != PH_DONE) && (bit_cnt == '1);
        rd_addr   = (phase == PH_INSTR) ? ins.addr : step_addr(cur_addr, lsb_first);
        wr_en     = byte_done && (phase == PH_DATA) && !rd_q;
        wr_addr   = cur_addr;
        wr_data   = rx_next;
        rd_phase  = (phase == PH_DATA) && rd_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !sel_act) begin
            phase    <= PH_INSTR;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rd_q     <= 1'b0;
            left     <= 2'd0;
            cur_addr <= '0;
            out_bit  <= 1'b0;
        end else begin
            if (rise && (phase != PH_DONE)) begin
                rx_sh   <= rx_next;
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (byte_done) begin
                if (phase == PH_INSTR) begin
                    rd_q     <= ins.rd;
                    left     <= ins.len;
                    cur_addr <= ins.addr;
                    phase    <= PH_DATA;
                    tx_sh    <= rd_data;
                end else if (left == 2'd0) begin
                    phase <= PH_DONE;
                end else begin
                    left     <= left - 2'd1;
                    cur_addr <= step_addr(cur_addr, lsb_first);
                    tx_sh    <= rd_data;
                end
            end else if (fall && rd_phase) begin
                out_bit <= lsb_first ? tx_sh[0] : tx_sh[BYTE_W-1];
                tx_sh   <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
            end
        end
    end
endmodule

// File: rtl/spi_cfg_regbank.sv
module spi_cfg_regbank
    import spi_cfg_pkg::*;
#(
    parameter addr_t RO_ADDR  = 5'h1F,
    parameter byte_t RO_VALUE = 8'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  addr_t             wr_addr,
    input  byte_t             wr_data,
    input  addr_t             rd_addr,
    output byte_t             rd_data,
    output logic [BANK_W-1:0] bank
);
    byte_t regs [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= reg_default(i);
        end else if (wr_en && (wr_addr != RO_ADDR)) begin
            if (wr_addr == '0) begin
                regs[0] <= wr_data & ~SRST_MASK;
                if (wr_data[CFG_SRST_BIT]) begin
                    for (int i = 1; i < NUM_REGS; i++) regs[i] <= reg_default(i);
                end
            end else begin
                regs[wr_addr] <= wr_data;
            end
        end
    end

    assign rd_data = (rd_addr == RO_ADDR) ? RO_VALUE : regs[rd_addr];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_bank
        assign bank[gi*BYTE_W +: BYTE_W] = (addr_t'(gi) == RO_ADDR) ? RO_VALUE : regs[gi];
    end
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int    SYNC_STAGES = 2,
    parameter addr_t RO_ADDR     = 5'h1F,
    parameter byte_t RO_VALUE    = 8'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              sdo_out,
    output logic              sdo_oe,
    output logic [BANK_W-1:0] cfg_bank
);
    logic  rise, fall, sel_act, sdi;
    logic  wr_en, out_bit, rd_phase;
    addr_t wr_addr, rd_addr;
    byte_t wr_data, rd_data;
    logic  bidir, lsb_first;

    spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sel_n_i(sel_n), .sdi_i(sdio_in),
        .sclk_rise(rise), .sclk_fall(fall), .sel_act(sel_act), .sdi(sdi)
    );

    spi_cfg_engine u_engine (
        .clk(clk), .rst(rst), .rise(rise), .fall(fall), .sel_act(sel_act),
        .sdi(sdi), .lsb_first(lsb_first), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .out_bit(out_bit), .rd_phase(rd_phase)
    );

    spi_cfg_regbank #(.RO_ADDR(RO_ADDR), .RO_VALUE(RO_VALUE)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .bank(cfg_bank)
    );

    assign bidir     = cfg_bank[CFG_BIDIR_BIT];
    assign lsb_first = cfg_bank[CFG_LSB_BIT];

    assign sdio_out = out_bit;
    assign sdo_out  = out_bit;
    assign sdio_oe  = sel_act && bidir && rd_phase;
    assign sdo_oe   = sel_act && !bidir;
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk
    import spi_cfg_pkg::*;
#(
    parameter addr_t RO_ADDR  = 5'h1F,
    parameter byte_t RO_VALUE = 8'h5A
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_n,
    input logic              sdio_oe,
    input logic              sdo_oe,
    input logic [BANK_W-1:0] cfg_bank
);
    logic [BANK_W-1:0] dflt;

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++)
            dflt[i*BYTE_W +: BYTE_W] = (addr_t'(i) == RO_ADDR) ? RO_VALUE : reg_default(i);
    end

    // R8
    no_dual_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !(sdio_oe && sdo_oe));

    // R8
    idle_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_n && $past(sel_n) && $past(sel_n, 2) && $past(sel_n, 3)) |-> (!sdio_oe && !sdo_oe));

    // R9
    srst_bit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_bank[CFG_SRST_BIT]);

    // R6
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_n && $past(sel_n) && $past(sel_n, 2) && $past(sel_n, 3)) |-> $stable(cfg_bank));

    // R10
    hw_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_bank == dflt));
endmodule

bind spi_cfg_port spi_cfg_port_chk #(.RO_ADDR(RO_ADDR), .RO_VALUE(RO_VALUE)) u_chk (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sdio_oe(sdio_oe),
    .sdo_oe(sdo_oe), .cfg_bank(cfg_bank)
);

// File: tb/spi_cfg_port_tb.sv
module spi_cfg_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 6;
    localparam logic [4:0] RO_A = 5'h1F;
    localparam logic [7:0] RO_V = 8'h5A;

    logic clk = 1'b0;
    logic rst, sel_n, sclk, sdio_in;
    logic sdio_out, sdio_oe, sdo_out, sdo_oe;
    logic [255:0] cfg_bank;

    spi_cfg_port u_dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out),
        .sdo_oe(sdo_oe), .cfg_bank(cfg_bank)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          idle_cmp = 0;
    bit          finished = 0;
    string       req = "R10";
    logic [7:0]  mreg [32];

    task automatic check(string r, bit ok, logic [255:0] act, logic [255:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    function automatic logic [7:0] m_def(int i);
        return (i == 1) ? 8'h02 : 8'h00;
    endfunction

    function automatic logic [7:0] m_read(logic [4:0] a);
        return (a == RO_A) ? RO_V : mreg[a];
    endfunction

    function automatic logic [255:0] m_flat();
        logic [255:0] f;
        for (int i = 0; i < 32; i++) f[i*8 +: 8] = m_read(5'(i));
        return f;
    endfunction

    task automatic m_write(logic [4:0] a, logic [7:0] d);
        if (a == RO_A) return;
        if (a == 5'd0) begin
            mreg[0] = {d[7:6], 1'b0, d[4:0]};
            if (d[5]) for (int i = 1; i < 32; i++) mreg[i] = m_def(i);
        end else begin
            mreg[a] = d;
        end
    endtask

    task automatic m_reset();
        for (int i = 0; i < 32; i++) mreg[i] = m_def(i);
    endtask

    // model compared against the bank and the enables on every idle clock
    always @(negedge clk) begin
        if (idle_cmp && !finished) begin
            check(req, cfg_bank == m_flat(), cfg_bank, m_flat());
            check("R8", !sdio_oe && !sdo_oe, {sdio_oe, sdo_oe}, 2'b00);
        end
    end

    task automatic clk_wait(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(bit b, output bit got, output bit oe_ok);
        bit bidir;
        bidir   = mreg[0][7];
        sdio_in = b;
        clk_wait(HALF_SCLK);
        got   = bidir ? sdio_out : sdo_out;
        oe_ok = bidir ? (sdio_oe && !sdo_oe) : (sdo_oe && !sdio_oe);
        sclk  = 1'b1;
        clk_wait(HALF_SCLK);
        sclk  = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] b, bit lsb, output logic [7:0] rx, output bit oe_all);
        bit g, o;
        oe_all = 1;
        for (int i = 0; i < 8; i++) begin
            int idx;
            idx = lsb ? i : 7 - i;
            send_bit(b[idx], g, o);
            rx[idx] = g;
            oe_all &= o;
        end
    endtask

    // one complete access, then `extra` surplus bytes in the same window
    task automatic access(string r, bit rd, int n, logic [4:0] a, logic [31:0] data, int extra);
        logic [7:0] rx, ins;
        logic [4:0] cur;
        bit ok, lsb;
        idle_cmp = 0;
        sel_n = 1'b0;
        clk_wait(4);
        ins = {rd, 2'(n - 1), a};             // R1 instruction layout
        send_byte(ins, mreg[0][6], rx, ok);
        cur = a;
        for (int k = 0; k < n; k++) begin
            lsb = mreg[0][6];
            send_byte(rd ? 8'h00 : data[8*k +: 8], lsb, rx, ok);
            if (rd) begin
                check(r, rx == m_read(cur), rx, m_read(cur));
                check("R8", ok, ok, 1);
            end else begin
                m_write(cur, data[8*k +: 8]);
            end
            cur = lsb ? 5'(cur + 1) : 5'(cur - 1);
        end
        for (int e = 0; e < extra; e++) send_byte(8'hC3, mreg[0][6], rx, ok);
        sel_n = 1'b1;
        clk_wait(8);
        req = r;
        idle_cmp = 1;
        clk_wait(3);
    endtask

    task automatic abort_write(logic [4:0] a, int nbits);
        logic [7:0] rx;
        bit g, o;
        idle_cmp = 0;
        sel_n = 1'b0;
        clk_wait(4);
        send_byte({1'b0, 2'b00, a}, mreg[0][6], rx, o);
        for (int i = 0; i < nbits; i++) send_bit(1'b1, g, o);
        sel_n = 1'b1;
        clk_wait(8);
        req = "R6";
        idle_cmp = 1;
        clk_wait(3);
    endtask

    initial begin
        rst = 1'b1; sel_n = 1'b1; sclk = 1'b0; sdio_in = 1'b0;
        m_reset();
        clk_wait(5);
        rst = 1'b0;
        clk_wait(2);
        check("R12", !sdio_oe && !sdo_oe, {sdio_oe, sdo_oe}, 2'b00);
        check("R10", cfg_bank == m_flat(), cfg_bank, m_flat());
        idle_cmp = 1;

        // R1 R2: single-byte write, MSB first
        access("R2", 0, 1, 5'h03, 32'h000000A5, 0);
        // R5 R8: read back on the separate output pin
        access("R5", 1, 1, 5'h03, 32'h0, 0);
        // R3: MSB-first descending 4-byte write
        access("R3", 0, 4, 5'h08, 32'h44332211, 0);
        // R3 R11: read crossing 00h -> 1Fh
        access("R3", 1, 3, 5'h01, 32'h0, 0);
        access("R5", 1, 4, 5'h08, 32'h0, 0);
        // R4: switch to LSB first
        access("R4", 0, 1, 5'h00, 32'h00000040, 0);
        access("R4", 0, 2, 5'h0A, 32'h00009C36, 0);
        access("R4", 1, 2, 5'h0A, 32'h0, 0);
        // R3 R11: LSB-first ascending crossing 1Fh -> 00h, RO write ignored
        access("R3", 0, 4, 5'h1E, 32'h33402211, 0);
        access("R3", 1, 4, 5'h1E, 32'h0, 0);
        // R4: ordering change written mid-access
        access("R4", 0, 2, 5'h00, 32'h00003C00, 0);
        access("R4", 1, 2, 5'h02, 32'h0, 0);
        // R8: bidirectional read on the shared pin
        access("R8", 0, 1, 5'h00, 32'h00000080, 0);
        access("R8", 1, 2, 5'h08, 32'h0, 0);
        access("R8", 0, 1, 5'h00, 32'h00000000, 0);
        // R6: aborted byte is never written
        abort_write(5'h06, 5);
        abort_write(5'h06, 7);
        access("R6", 0, 1, 5'h06, 32'h0000007E, 0);
        // R7: surplus bytes do nothing
        access("R7", 0, 1, 5'h0C, 32'h00000011, 2);
        access("R7", 1, 1, 5'h0B, 32'h0, 3);
        // R11: read-only address
        access("R11", 0, 1, 5'h1F, 32'h000000FF, 0);
        access("R11", 1, 1, 5'h1F, 32'h0, 0);
        // R9: soft reset, keeps ordering bit, reset bit reads 0
        access("R9", 0, 1, 5'h00, 32'h00000060, 0);
        access("R9", 1, 2, 5'h00, 32'h0, 0);
        access("R9", 1, 1, 5'h03, 32'h0, 0);
        // R10: hardware reset clears register 0 as well
        access("R10", 0, 1, 5'h05, 32'h000000EE, 0);
        idle_cmp = 0;
        rst = 1'b1;
        clk_wait(3);
        rst = 1'b0;
        m_reset();
        clk_wait(2);
        check("R10", cfg_bank == m_flat(), cfg_bank, m_flat());
        check("R12", !sdio_oe && !sdo_oe, {sdio_oe, sdo_oe}, 2'b00);
        req = "R10";
        idle_cmp = 1;
        access("R10", 1, 1, 5'h01, 32'h0, 0);

        idle_cmp = 0;
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule